// File: doc/BRIEF.md
# Quad Double-Buffered DAC Command Decoder

This block sits behind the serial receiver of a four-channel converter. Each channel has two 12-bit stages: a staging register and an output-code register. Whenever the receiver finishes a 16-bit word, it pulses a commit strobe. The block then decodes the top four bits of the word as a 2-bit channel select and a 2-bit control field, and acts on it in one cycle.

The actions are:
- stage a code without disturbing the outputs;
- stage a code and move every staged code to the outputs;
- copy all staged codes to the outputs;
- write one code everywhere;
- drive a general-purpose logic pin;
- choose which shift-clock edge the echo output uses;
- enter a low-power state.

A lockout pin can veto the low-power state. While the block is powered down, a falling edge on the lockout pin wakes it. Any command that writes the output-code registers also wakes it. After a wake, a ready flag stays low for a programmable number of cycles. This covers the time the analog outputs need to settle.

The lockout pin and the commit strobe are assumed synchronous to `clk`. The clear input acts asynchronously.

Top module: `quad_dac_cmd`

## Requirements
- R1: After the synchronous reset or while the asynchronous clear is low, all staging and output-code registers are zero, `user_o` is 0, `echo_mode_o` is 0, `shutdown_o` is 0 and `ready_o` is 1.
- R2: With control field word[13:12] = 01, word[11:0] goes to the staging register chosen by word[15:14] (00 = channel 0 ... 11 = channel 3), and no output code changes.
- R3: With control field 11, the selected staging register takes word[11:0], and in the same cycle every output code takes its channel's staging value, including the new one.
- R4: Code word[15:12] = 0100 copies every staging register to its output code.
- R5: Code 1000 writes word[11:0] into all four staging and all four output-code registers.
- R6: Code 1100 sets `shutdown_o` only when `lock_n_i` is 1. Staging and output-code contents are kept while powered down.
- R7: Code 0010 clears `user_o` and code 0110 sets it.
- R8: Code 0000 changes no register and no output.
- R9: Code 1110 sets `echo_mode_o` to 1 and code 1010 sets it to 0. Both also copy all staging registers to the output codes.
- R10: While powered down, a 1-to-0 change of `lock_n_i` between two clock edges clears `shutdown_o` at the second edge. The output codes are those held before the power-down.
- R11: Codes 0100, 1000, 1010, 1110 and any code with control field 11 clear `shutdown_o`.
- R12: `ready_o` is 0 while powered down. It rises exactly `SETTLE_CYCLES` clock edges after the edge that cleared `shutdown_o`.
- R13: Every result of a commit is visible on the outputs after the clock edge that samples `commit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear |
| word_i | input | 16 | Command word: [15:14] select, [13:12] control, [11:0] data |
| commit_i | input | 1 | One-cycle strobe marking a complete word |
| lock_n_i | input | 1 | Power-down lockout, low blocks power-down |
| dac_code_o | output | 48 | Output codes, channel n at [12n+11:12n] |
| shutdown_o | output | 1 | Powered-down state |
| user_o | output | 1 | General-purpose logic output |
| echo_mode_o | output | 1 | Echo edge select: 0 falling, 1 rising |
| ready_o | output | 1 | Outputs settled after leaving power-down |

## Verification
The results of a commit (codes, user pin, echo mode, power state) are due one edge after the commit is sampled. A lockout fall lands on the edge after the one that saw the pin high. `ready_o` follows `SETTLE_CYCLES` edges after that. The bench drives inputs just after the falling clock edge and keeps a behavioural model that steps on every rising edge. It compares all outputs at each falling edge, so every due value is read half a cycle after the edge that produced it. Directed checks at the same sampling point pin down the exact cycle in which `ready_o` rises.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the quad DAC command decoder.
// Assumes the fixed word layout: 2 select bits, 2 control bits, data.
package qdac_pkg;
    localparam int NUM_CH = 4;
    localparam int SEL_W  = $clog2(NUM_CH);
    localparam int DATA_W = 12;
    localparam int WORD_W = SEL_W + 2 + DATA_W;

    // Control field meanings
    typedef enum logic [1:0] {
        CC_SYS   = 2'b00,  // global actions selected by the select bits
        CC_LOAD  = 2'b01,  // stage only
        CC_AUX   = 2'b10,  // user pin and echo mode
        CC_LDUPD = 2'b11   // stage and transfer all
    } ctl_e;

    // Decoded command
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              wr_one;
        logic              upd_all;
        logic              bcast;
        logic              xfer;
        logic              shdn;
        logic              user_wr;
        logic              user_val;
        logic              mode_wr;
        logic              mode_val;
        logic [DATA_W-1:0] data;
    } dec_t;
endpackage

// File: rtl/qdac_decode.sv
`timescale 1ns/1ps
// Combinational decoder from a command word to action flags.
// Assumes word layout {sel, ctl, data}; no state.
module qdac_decode
    import qdac_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o
);
    ctl_e             ctl;
    logic [SEL_W-1:0] sel;

    assign ctl = ctl_e'(word_i[DATA_W +: 2]);
    assign sel = word_i[DATA_W+2 +: SEL_W];

    // Map control field and select onto action flags
    always_comb begin
        dec_o      = '0;
        dec_o.sel  = sel;
        dec_o.data = word_i[DATA_W-1:0];
        case (ctl)
            CC_LOAD:  dec_o.wr_one = 1'b1;
            CC_LDUPD: begin
                dec_o.wr_one  = 1'b1;
                dec_o.upd_all = 1'b1;
            end
            CC_SYS: begin
                case (sel)
                    2'd1:    dec_o.xfer  = 1'b1;
                    2'd2:    dec_o.bcast = 1'b1;
                    2'd3:    dec_o.shdn  = 1'b1;
                    default: ;
                endcase
            end
            CC_AUX: begin
                if (sel[1]) begin
                    dec_o.mode_wr  = 1'b1;
                    dec_o.mode_val = sel[0];
                    dec_o.xfer     = 1'b1;
                end else begin
                    dec_o.user_wr  = 1'b1;
                    dec_o.user_val = sel[0];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qdac_channel.sv
`timescale 1ns/1ps
// One converter channel: staging register followed by output-code register.
// Assumes ld_val_i and xfer_i are never both set in one cycle.
module qdac_channel #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         wr_i,
    input  logic [W-1:0] val_i,
    input  logic         ld_val_i,
    input  logic         xfer_i,
    output logic [W-1:0] dac_o
);
    logic [W-1:0] stage_q;
    logic [W-1:0] code_q;

    // Staging and output-code registers with async clear and sync reset
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stage_q <= '0;
            code_q  <= '0;
        end else if (!rst_n) begin
            stage_q <= '0;
            code_q  <= '0;
        end else begin
            if (wr_i)
                stage_q <= val_i;
            if (ld_val_i)
                code_q <= val_i;
            else if (xfer_i)
                code_q <= stage_q;
        end
    end

    assign dac_o = code_q;
endmodule

// File: rtl/qdac_power.sv
`timescale 1ns/1ps
// Power-down state with lockout veto, wake on lockout fall or on output
// write, and a settle counter that gates the ready flag.
// Assumes lock_n_i is synchronous to clk.
module qdac_power #(
    parameter int SETTLE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic lock_n_i,
    input  logic enter_i,
    input  logic wake_i,
    output logic shut_o,
    output logic ready_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 2);

    logic             lock_q;
    logic             shut_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fall;
    logic             enter;
    logic             leave;

    assign fall  = lock_q & ~lock_n_i;
    assign enter = enter_i & lock_n_i;
    assign leave = wake_i | fall;

    // Track lockout pin, power state and settle countdown
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            lock_q <= 1'b0;
            shut_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!rst_n) begin
            lock_q <= 1'b0;
            shut_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            lock_q <= lock_n_i;
            if (enter) begin
                shut_q <= 1'b1;
                cnt_q  <= '0;
            end else if (shut_q && leave) begin
                shut_q <= 1'b0;
                cnt_q  <= CNT_W'(SETTLE_CYCLES);
            end else if (!shut_q && cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign shut_o  = shut_q;
    assign ready_o = ~shut_q & (cnt_q == '0);
endmodule

// File: rtl/quad_dac_cmd.sv
`timescale 1ns/1ps
// Top of the quad DAC command decoder: decodes committed words, updates
// four double-buffered channels, the user pin, the echo mode and power state.
// Assumes commit_i is a one-cycle strobe synchronous to clk.
module quad_dac_cmd
    import qdac_pkg::*;
#(
    parameter int SETTLE_CYCLES = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_n,
    input  logic [WORD_W-1:0]        word_i,
    input  logic                     commit_i,
    input  logic                     lock_n_i,
    output logic [NUM_CH*DATA_W-1:0] dac_code_o,
    output logic                     shutdown_o,
    output logic                     user_o,
    output logic                     echo_mode_o,
    output logic                     ready_o
);
    dec_t dec;
    logic wake_cmd;
    logic user_q;
    logic mode_q;

    qdac_decode u_dec (
        .word_i (word_i),
        .dec_o  (dec)
    );

    assign wake_cmd = commit_i & (dec.upd_all | dec.bcast | dec.xfer);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        logic wr;
        logic ld_val;
        logic xfer;

        assign hit    = (dec.sel == SEL_W'(g));
        assign wr     = commit_i & ((dec.wr_one & hit) | dec.bcast);
        assign ld_val = commit_i & ((dec.upd_all & hit) | dec.bcast);
        assign xfer   = commit_i & ((dec.upd_all & ~hit) | dec.xfer);

        qdac_channel #(.W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_n    (clr_n),
            .wr_i     (wr),
            .val_i    (dec.data),
            .ld_val_i (ld_val),
            .xfer_i   (xfer),
            .dac_o    (dac_code_o[g*DATA_W +: DATA_W])
        );
    end

    qdac_power #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .lock_n_i (lock_n_i),
        .enter_i  (commit_i & dec.shdn),
        .wake_i   (wake_cmd),
        .shut_o   (shutdown_o),
        .ready_o  (ready_o)
    );

    // User pin and echo-mode bit written by auxiliary commands
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            user_q <= 1'b0;
            mode_q <= 1'b0;
        end else if (!rst_n) begin
            user_q <= 1'b0;
            mode_q <= 1'b0;
        end else if (commit_i) begin
            if (dec.user_wr)
                user_q <= dec.user_val;
            if (dec.mode_wr)
                mode_q <= dec.mode_val;
        end
    end

    assign user_o      = user_q;
    assign echo_mode_o = mode_q;
endmodule

// File: rtl/qdac_chk.sv
`timescale 1ns/1ps
// Protocol checker for quad_dac_cmd, attached by bind; observes ports only.
module qdac_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr_n,
    input logic [15:0] word_i,
    input logic        commit_i,
    input logic        lock_n_i,
    input logic [47:0] dac_code_o,
    input logic        shutdown_o,
    input logic        user_o,
    input logic        echo_mode_o,
    input logic        ready_o
);
    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[13:12] == 2'b01 |=> $stable(dac_code_o));

    assert_shdn_enter_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[15:12] == 4'hC && lock_n_i |=> shutdown_o);

    assert_shdn_veto_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[15:12] == 4'hC && !lock_n_i && !shutdown_o |=> !shutdown_o);

    assert_user_high_R7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[15:12] == 4'h6 |=> user_o);

    assert_user_low_R7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[15:12] == 4'h2 |=> !user_o);

    assert_nop_R8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[15:12] == 4'h0 |=>
        $stable(dac_code_o) && $stable(user_o) && $stable(echo_mode_o));

    assert_mode_rise_R9: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[15:12] == 4'hE |=> echo_mode_o);

    assert_mode_fall_R9: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[15:12] == 4'hA |=> !echo_mode_o);

    assert_lock_wake_R10: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        shutdown_o && $past(lock_n_i) && !lock_n_i |=> !shutdown_o);

    assert_cmd_wake_R11: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        commit_i && word_i[15:12] == 4'h4 |=> !shutdown_o);

    assert_ready_low_R12: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        shutdown_o |-> !ready_o);
endmodule

bind quad_dac_cmd qdac_chk i_chk (.*);

// File: tb/test_quad_dac_cmd.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference model compared every cycle,
// plus directed checks at the cycle each result is due.
module test_quad_dac_cmd;
    localparam int SETTLE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic [15:0] word = '0;
    logic        commit = 1'b0;
    logic        lock_n = 1'b1;
    logic [47:0] dac_code_o;
    logic        shutdown_o, user_o, echo_mode_o, ready_o;

    always #5 clk = ~clk;

    quad_dac_cmd #(.SETTLE_CYCLES(SETTLE)) i_quad_dac_cmd (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .word_i(word),
        .commit_i(commit), .lock_n_i(lock_n), .dac_code_o(dac_code_o),
        .shutdown_o(shutdown_o), .user_o(user_o), .echo_mode_o(echo_mode_o),
        .ready_o(ready_o)
    );

    int    n_run = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    cmp_on = 0;

    int m_stage[4];
    int m_code[4];
    bit m_user, m_mode, m_shut, m_lockq;
    int m_cnt;

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int code_of(int ch);
        return int'(dac_code_o[ch*12 +: 12]);
    endfunction

    // Reference model: behaviour from the requirements, stepped per edge
    always @(posedge clk or negedge clr_n) begin
        int sel, ctl, d;
        bit fall, wake, enter;
        if (!clr_n || !rst_n) begin
            foreach (m_stage[i]) begin m_stage[i] = 0; m_code[i] = 0; end
            m_user = 0; m_mode = 0; m_shut = 0; m_lockq = 0; m_cnt = 0;
        end else begin
            sel = word[15:14]; ctl = word[13:12]; d = word[11:0];
            wake = 0; enter = 0;
            fall = m_lockq && !lock_n;
            if (commit) begin
                if (ctl == 1) m_stage[sel] = d;
                else if (ctl == 3) begin
                    m_stage[sel] = d;
                    foreach (m_code[i]) m_code[i] = m_stage[i];
                    wake = 1;
                end else if (ctl == 0) begin
                    if (sel == 1) begin
                        foreach (m_code[i]) m_code[i] = m_stage[i];
                        wake = 1;
                    end else if (sel == 2) begin
                        foreach (m_code[i]) begin m_stage[i] = d; m_code[i] = d; end
                        wake = 1;
                    end else if (sel == 3) enter = lock_n;
                end else begin
                    if (sel < 2) m_user = sel[0];
                    else begin
                        m_mode = sel[0];
                        foreach (m_code[i]) m_code[i] = m_stage[i];
                        wake = 1;
                    end
                end
            end
            if (enter) begin m_shut = 1; m_cnt = 0; end
            else if (m_shut && (wake || fall)) begin m_shut = 0; m_cnt = SETTLE; end
            else if (!m_shut && m_cnt > 0) m_cnt = m_cnt - 1;
            m_lockq = lock_n;
        end
    end

    // Compare every output with the model half a cycle after each edge
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int i = 0; i < 4; i++) chk(tag, code_of(i), m_code[i]);
            chk(tag, user_o, m_user);
            chk(tag, echo_mode_o, m_mode);
            chk(tag, shutdown_o, m_shut);
            chk(tag, ready_o, (!m_shut && m_cnt == 0));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic send(logic [3:0] c, logic [11:0] d);
        step();
        word = {c, d};
        commit = 1'b1;
        step();
        commit = 1'b0;
    endtask

    task automatic chk_codes(string req, int a, int b, int c, int d);
        chk(req, code_of(0), a);
        chk(req, code_of(1), b);
        chk(req, code_of(2), c);
        chk(req, code_of(3), d);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        cmp_on = 1;
        step();
        tag = "R1";
        chk_codes("R1", 0, 0, 0, 0);
        chk("R1", user_o, 0); chk("R1", echo_mode_o, 0);
        chk("R1", shutdown_o, 0); chk("R1", ready_o, 1);

        tag = "R2";
        send(4'h1, 12'h123); send(4'h5, 12'h456);
        send(4'h9, 12'h789); send(4'hD, 12'hABC);
        chk_codes("R2", 0, 0, 0, 0);

        tag = "R4";
        send(4'h4, 12'h000);
        chk_codes("R4", 12'h123, 12'h456, 12'h789, 12'hABC);

        tag = "R3";
        send(4'h1, 12'h111);
        chk("R2", code_of(0), 12'h123);
        send(4'hB, 12'h222);
        chk_codes("R3", 12'h111, 12'h456, 12'h222, 12'hABC);

        tag = "R8";
        send(4'h0, 12'hFFF);
        chk_codes("R8", 12'h111, 12'h456, 12'h222, 12'hABC);
        chk("R8", user_o, 0);

        tag = "R7";
        send(4'h6, 12'h000); chk("R7", user_o, 1);
        send(4'h2, 12'h000); chk("R7", user_o, 0);

        tag = "R9";
        send(4'h1, 12'h333);
        send(4'hE, 12'h000);
        chk("R9", echo_mode_o, 1); chk("R9", code_of(0), 12'h333);
        send(4'h1, 12'h3A3);
        send(4'hA, 12'h000);
        chk("R9", echo_mode_o, 0); chk("R9", code_of(0), 12'h3A3);

        tag = "R6";
        lock_n = 1'b0;
        send(4'hC, 12'h000); chk("R6", shutdown_o, 0);
        lock_n = 1'b1; step();
        send(4'hC, 12'h000);
        chk("R6", shutdown_o, 1); chk("R12", ready_o, 0);
        send(4'h5, 12'h5AA);
        chk("R6", shutdown_o, 1); chk("R6", code_of(1), 12'h456);

        tag = "R10";
        lock_n = 1'b0;
        step();
        chk("R10", shutdown_o, 0);
        chk_codes("R10", 12'h3A3, 12'h456, 12'h222, 12'hABC);
        tag = "R12";
        chk("R12", ready_o, 0);
        repeat (SETTLE - 1) step();
        chk("R12", ready_o, 0);
        step();
        chk("R12", ready_o, 1);

        tag = "R5";
        lock_n = 1'b1; step();
        send(4'hC, 12'h000); chk("R11", shutdown_o, 1);
        send(4'h8, 12'h5C5);
        chk("R11", shutdown_o, 0);
        chk_codes("R5", 12'h5C5, 12'h5C5, 12'h5C5, 12'h5C5);
        send(4'h4, 12'h000);
        chk_codes("R5", 12'h5C5, 12'h5C5, 12'h5C5, 12'h5C5);

        tag = "R11";
        send(4'hC, 12'h000); chk("R11", shutdown_o, 1);
        send(4'h4, 12'h000); chk("R11", shutdown_o, 0);
        repeat (SETTLE + 1) step();
        chk("R13", ready_o, 1);

        tag = "R1";
        send(4'h6, 12'h000); send(4'hE, 12'h000);
        step(); clr_n = 1'b0; step(); step();
        chk_codes("R1", 0, 0, 0, 0);
        chk("R1", user_o, 0); chk("R1", echo_mode_o, 0);
        chk("R1", shutdown_o, 0); chk("R1", ready_o, 1);
        clr_n = 1'b1;
        repeat (3) step();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule